// File: doc/BRIEF.md
# MDIO Management Command Engine

This block gives a processor a single 32-bit command/status word through which it runs one management transaction at a time on a PHY's two-wire management bus (MDC clock, bidirectional MDIO data). Writing the word supplies the PHY address, register address, direction and, for writes, the data. The engine then shifts out a complete clause-22 style frame, shows a busy flag for as long as the command is outstanding, and for a read places the returned 16 bits back into the low half of the word with a read-valid flag. A one-cycle done pulse goes to the interrupt logic when a processor command finishes.

An optional background poller reads register 1 of a chosen PHY at a fixed interval whenever the bus has nothing else to do. It keeps the last value it saw and pulses a change output whenever a new reading differs from it. Processor commands always win the bus over the poller, and poll traffic never touches the processor-visible word or the done pulse.

MDC is made by dividing the system clock. MDIO is launched on the falling edge of MDC and sampled on its rising edge. The output enable is released for the turnaround and the data phase of a read so that the PHY can drive the line.

Top module: `mdio_cmd_engine`

## Requirements
- R1: While reset is asserted the status word reads 0, MDC is low, the MDIO output enable is low and the done and change outputs are low.
- R2: An accepted command word is visible in the status word from the next cycle with data in bits 15:0, PHY address in bits 20:16, register address in bits 25:21 and the direction in bit 26 (1 = read, 0 = write); bits 31:29 read 0.
- R3: Busy (bit 28) is 1 from the cycle after a command is accepted until the frame ends; it drops in the same cycle that the done output pulses for exactly one cycle.
- R4: A write frame on the wire is 32 ones, then 01, 01, the PHY address, the register address, 10 and the 16 data bits, all MSB first, 64 bits in total.
- R5: A read frame carries 32 ones, 01, 10, the PHY address and the register address, then the engine stops driving MDIO (output enable low) for the two turnaround bits and the 16 data bits.
- R6: When a read completes, the 16 bits sampled from MDIO (MSB first) appear in bits 15:0 and read-valid (bit 27) is set; read-valid clears in the cycle after the next command is accepted.
- R7: A command write while busy is 1 is ignored: the status word fields and the bus traffic are unchanged by it.
- R8: MDC has a period of 2*DIV_HALF system clocks, and MDIO changes only at the falling edge of MDC.
- R9: With polling enabled, the engine reads register 1 of the selected PHY after every POLL_GAP idle cycles; the first reading after enabling is only stored, and each later reading that differs from the stored value gives a one-cycle change pulse.
- R10: A pending processor command is started before any poll frame, and poll results never alter the status word.
- R11: The done output pulses only for processor commands, never for poll frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Command/status word |
| done_pulse | output | 1 | One-cycle pulse when a processor command completes |
| poll_en | input | 1 | Enables the register-1 poller |
| poll_phy | input | 5 | PHY address the poller reads |
| phy_change | output | 1 | One-cycle pulse when the polled value changes |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The bench sweeps every PHY address with writes and reads against a responder model and checks each wire frame bit by bit. A wrong opcode or field order would corrupt the captured frames, and an engine that kept driving through the turnaround would be caught by the responder. It targets a command written while busy, which a faulty design would latch as new fields or an extra frame, and the clearing of read-valid on the next command. The poller is checked with a stable register, which must give no change pulse even after the first baseline read, and then with a changed one, which must give exactly one pulse. Processor reads issued while polling is active must return their own data, because a design that let poll results leak into the status word would overwrite it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;
  localparam int TA_IDX     = PRE_BITS + HDR_BITS;
  localparam int DATA_IDX   = TA_IDX + 2;

  // status word bit positions (software decodes these)
  localparam int W_PHY_LSB  = 16;
  localparam int W_REG_LSB  = 21;
  localparam int W_OP_BIT   = 26;
  localparam int W_RDV_BIT  = 27;
  localparam int W_BUSY_BIT = 28;

  typedef struct packed {
    logic [4:0]  reg_a;
    logic [4:0]  phy;
    logic        rd;
    logic [15:0] data;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
    logic [1:0] op;
    logic [1:0] ta;
    op = r.rd ? 2'b10 : 2'b01;
    ta = r.rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.reg_a, ta,
            (r.rd ? 16'hFFFF : r.data)};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = (cnt_q == CW'(DIV_HALF - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    mdc_d = tick ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick & ~mdc_q;
  assign fall_stb = tick &  mdc_q;

  p_rise_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
  p_fall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        mdio_i,
  output logic        idle,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  act_q, act_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic [15:0]           rdsh_q, rdsh_d;
  logic                  mo_q, mo_d;
  logic                  oe_q, oe_d;
  logic                  done_q, done_d;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    rdsh_d = rdsh_q;
    mo_d   = mo_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    if (start && !act_q) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      sh_d   = build_frame(req);
      rd_d   = req.rd;
      rdsh_d = '0;
    end else if (act_q && fall_stb) begin
      if (cnt_q == CNT_W'(FRAME_BITS)) begin
        act_d  = 1'b0;
        oe_d   = 1'b0;
        mo_d   = 1'b1;
        done_d = 1'b1;
      end else begin
        mo_d  = sh_q[FRAME_BITS-1];
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        oe_d  = !rd_q || (cnt_q < CNT_W'(TA_IDX));
        cnt_d = cnt_q + 1'b1;
      end
    end else if (act_q && rise_stb && rd_q && (cnt_q > CNT_W'(DATA_IDX))) begin
      rdsh_d = {rdsh_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      rdsh_q <= '0;
      mo_q   <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      rdsh_q <= rdsh_d;
      mo_q   <= mo_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  assign idle    = !act_q;
  assign done    = done_q;
  assign rd_data = rdsh_q;
  assign mdio_o  = mo_q;
  assign mdio_oe = oe_q;

  // R5: bus released once the turnaround of a read has begun
  p_ta_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rd_q && (cnt_q > CNT_W'(TA_IDX))) |-> !mdio_oe);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);
  p_oe_only_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !idle);

endmodule

// File: rtl/mdio_poller.sv
module mdio_poller #(
  parameter int POLL_GAP = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        grant,
  input  logic        result_vld,
  input  logic [15:0] result,
  output logic        due,
  output logic        change
);
  localparam int TW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

  logic [TW-1:0] tmr_q, tmr_d;
  logic          due_q, due_d;
  logic          wait_q, wait_d;
  logic          bvld_q, bvld_d;
  logic [15:0]   base_q, base_d;
  logic          chg_q, chg_d;

  always_comb begin
    tmr_d  = tmr_q;
    due_d  = due_q;
    wait_d = wait_q;
    bvld_d = bvld_q;
    base_d = base_q;
    chg_d  = 1'b0;
    if (!enable) begin
      tmr_d  = '0;
      due_d  = 1'b0;
      bvld_d = 1'b0;
    end else if (!due_q && !wait_q) begin
      if (tmr_q == TW'(POLL_GAP - 1)) begin
        tmr_d = '0;
        due_d = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
    if (grant) begin
      due_d  = 1'b0;
      wait_d = 1'b1;
    end
    if (result_vld) begin
      wait_d = 1'b0;
      if (enable) begin
        chg_d  = bvld_q && (result != base_q);
        base_d = result;
        bvld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      due_q  <= 1'b0;
      wait_q <= 1'b0;
      bvld_q <= 1'b0;
      base_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      due_q  <= due_d;
      wait_q <= wait_d;
      bvld_q <= bvld_d;
      base_q <= base_d;
      chg_q  <= chg_d;
    end
  end

  assign due    = due_q;
  assign change = chg_q;

  p_change_after_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    change |-> $past(result_vld));
  p_grant_when_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> due);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int POLL_GAP = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        done_pulse,
  input  logic        poll_en,
  input  logic [4:0]  poll_phy,
  output logic        phy_change,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [4:0] STATUS_REG = 5'd1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic        rise_stb, fall_stb;
  logic        shf_idle, shf_done;
  logic [15:0] shf_rd;
  logic        shf_start;
  mdio_req_t   shf_req;
  logic        poll_due, poll_grant, poll_rvld;

  mdio_req_t fld_q, fld_d;
  logic      rdv_q, rdv_d;
  logic      pend_q, pend_d;
  logic      cact_q, cact_d;
  logic      pact_q, pact_d;
  logic      done_q, done_d;
  logic      busy, accept, go_cpu, go_poll;
  logic      unused_hi;

  assign unused_hi = ^cmd_wdata[31:27];
  assign busy      = pend_q | cact_q;
  assign accept    = cmd_wr & ~busy;
  assign go_cpu    = shf_idle & pend_q;
  assign go_poll   = shf_idle & ~pend_q & poll_due;
  assign shf_start = go_cpu | go_poll;
  assign poll_grant = go_poll;
  assign poll_rvld  = shf_done & pact_q;

  always_comb begin
    if (go_cpu) shf_req = fld_q;
    else        shf_req = '{reg_a: STATUS_REG, phy: poll_phy, rd: 1'b1, data: 16'h0};
  end

  always_comb begin
    fld_d  = fld_q;
    rdv_d  = rdv_q;
    pend_d = pend_q;
    cact_d = cact_q;
    pact_d = pact_q;
    done_d = 1'b0;
    if (accept) begin
      fld_d.data  = cmd_wdata[15:0];
      fld_d.phy   = cmd_wdata[W_PHY_LSB +: 5];
      fld_d.reg_a = cmd_wdata[W_REG_LSB +: 5];
      fld_d.rd    = cmd_wdata[W_OP_BIT];
      rdv_d       = 1'b0;
      pend_d      = 1'b1;
    end
    if (go_cpu) begin
      pend_d = 1'b0;
      cact_d = 1'b1;
    end
    if (go_poll) pact_d = 1'b1;
    if (shf_done && cact_q) begin
      cact_d = 1'b0;
      done_d = 1'b1;
      if (fld_q.rd) begin
        fld_d.data = shf_rd;
        rdv_d      = 1'b1;
      end
    end
    if (shf_done && pact_q) pact_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q  <= '0;
      rdv_q  <= 1'b0;
      pend_q <= 1'b0;
      cact_q <= 1'b0;
      pact_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      rdv_q  <= rdv_d;
      pend_q <= pend_d;
      cact_q <= cact_d;
      pact_q <= pact_d;
      done_q <= done_d;
    end
  end

  assign cmd_rdata  = {3'b000, busy, rdv_q, fld_q.rd, fld_q.reg_a, fld_q.phy, fld_q.data};
  assign done_pulse = done_q;

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_ni), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_shifter u_shf (
    .clk(clk), .rst_n(rst_ni), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .start(shf_start), .req(shf_req), .mdio_i(mdio_i), .idle(shf_idle),
    .done(shf_done), .rd_data(shf_rd), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_poller #(.POLL_GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst_n(rst_ni), .enable(poll_en), .grant(poll_grant),
    .result_vld(poll_rvld), .result(shf_rd), .due(poll_due), .change(phy_change)
  );

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> cmd_rdata[W_BUSY_BIT]);
  p_done_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    done_pulse |-> !cmd_rdata[W_BUSY_BIT]);
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && busy) |=> $stable(cmd_rdata[W_OP_BIT:W_PHY_LSB]));
  p_rdv_with_done_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cmd_rdata[W_RDV_BIT]) |-> done_pulse);
  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(mdio_o) |-> !mdc);
  p_done_cpu_only_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    done_pulse |-> $past(cact_q));
  p_cpu_first_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (shf_idle && pend_q) |=> !pact_q);

endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int DIVH = 2;
  localparam int GAP  = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        done_pulse;
  logic        poll_en = 1'b0;
  logic [4:0]  poll_phy = 5'd5;
  logic        phy_change;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i_r = 1'b1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int done_cnt = 0;
  int chg_cnt = 0;

  always #10 clk = ~clk;

  mdio_cmd_engine #(.DIV_HALF(DIVH), .POLL_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .done_pulse(done_pulse), .poll_en(poll_en),
    .poll_phy(poll_phy), .phy_change(phy_change), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i_r)
  );

  always @(posedge clk) begin
    cyc++;
    if (done_pulse) done_cnt++;
    if (phy_change) chg_cnt++;
  end

  // PHY responder model
  logic [15:0] preg [32][32];
  logic        in_fr = 1'b0;
  int          idx = 0;
  logic [63:0] cap = '0;
  logic        rd_fl = 1'b0;
  logic        ta_bad = 1'b0;
  logic [15:0] rdval = '0;
  logic [63:0] last_frame = '0;
  logic        last_ta_bad = 1'b0;
  int          nframes = 0;
  int          npoll = 0;

  always @(posedge mdc) begin
    if (!in_fr && mdio_oe) begin
      in_fr = 1'b1; idx = 0; rd_fl = 1'b0; ta_bad = 1'b0;
    end
    if (in_fr) begin
      cap = {cap[62:0], (mdio_oe ? mdio_o : mdio_i_r)};
      if (rd_fl && mdio_oe) ta_bad = 1'b1;
      idx++;
      if (idx == 46) begin
        rd_fl = (cap[11:10] == 2'b10);
        rdval = preg[cap[9:5]][cap[4:0]];
      end
      if (idx == 64) begin
        in_fr = 1'b0;
        last_frame = cap;
        last_ta_bad = ta_bad;
        nframes++;
        if (!rd_fl) preg[cap[27:23]][cap[22:18]] = cap[15:0];
        else if (cap[27:23] == poll_phy && cap[22:18] == 5'd1) npoll++;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_fr && rd_fl) begin
      if (idx == 46)      mdio_i_r = 1'b1;
      else if (idx == 47) mdio_i_r = 1'b0;
      else if (idx < 64)  mdio_i_r = rdval[63 - idx];
    end else begin
      mdio_i_r = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wdat(int p);
    return 16'((p * 4099 + 11) & 16'hFFFF);
  endfunction

  function automatic logic [31:0] mkcmd(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {5'b0, rd, r, p, d};
  endfunction

  // issue a command, check acceptance, wait for completion
  task automatic run_cmd(input logic [31:0] w, input string tag);
    int d0, guard;
    d0 = done_cnt;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[26:0] == w[26:0] && cmd_rdata[31:29] == 3'b0, {tag, " R2 fields"}, cmd_rdata, w);
    chk(cmd_rdata[28] == 1'b1 && cmd_rdata[27] == 1'b0, {tag, " R3/R6 busy set, valid clear"}, cmd_rdata[28:27], 2'b10);
    guard = 0;
    while (cmd_rdata[28] && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_pulse == 1'b1, {tag, " R3 done with busy drop"}, done_pulse, 1);
    @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " R11 one done per command"}, done_cnt, d0 + 1);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0, t1, c0, f0, p0;
    logic [31:0] w;
    logic [15:0] base;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        preg[p][r] = 16'((p * 2053 + r * 97 + 4660) & 16'hFFFF);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cmd_rdata == 32'h0, "R1 status word", cmd_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe low", {mdc, mdio_oe}, 0);
    chk(done_pulse == 1'b0 && phy_change == 1'b0, "R1 pulses low", {done_pulse, phy_change}, 0);
    rst_n = 1'b1;
    wait_cyc(5);

    // R8: MDC period
    @(posedge mdc); t0 = cyc;
    @(posedge mdc); t1 = cyc;
    chk(t1 - t0 == 2 * DIVH, "R8 mdc period", t1 - t0, 2 * DIVH);

    // write sweep over all PHY addresses (R4)
    for (int p = 0; p < 32; p++) begin
      logic [4:0] r;
      r = 5'((p * 5 + 2) % 32);
      w = mkcmd(1'b0, 5'(p), r, wdat(p));
      run_cmd(w, "wr");
      chk(last_frame == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(p), r, 2'b10, wdat(p)},
          "R4 write frame", last_frame, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(p), r, 2'b10, wdat(p)});
    end

    // read sweep: written and untouched locations (R5, R6)
    for (int p = 0; p < 32; p++) begin
      logic [4:0] r, r2;
      r  = 5'((p * 5 + 2) % 32);
      r2 = 5'((p * 3 + 1) % 32);
      run_cmd(mkcmd(1'b1, 5'(p), r, 16'h0), "rd");
      chk(cmd_rdata[27] == 1'b1 && cmd_rdata[15:0] == wdat(p), "R6 read data", cmd_rdata[27:0], {1'b1, 11'h0, wdat(p)});
      chk(last_frame[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(p), r} && !last_ta_bad,
          "R5 read header/turnaround", last_frame[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(p), r});
      run_cmd(mkcmd(1'b1, 5'(p), r2, 16'h0), "rd2");
      chk(cmd_rdata[15:0] == 16'((p * 2053 + r2 * 97 + 4660) & 16'hFFFF), "R6 read untouched",
          cmd_rdata[15:0], 16'((p * 2053 + r2 * 97 + 4660) & 16'hFFFF));
    end

    // R6: read-valid cleared by next accepted command
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = mkcmd(1'b0, 5'd3, 5'd9, 16'hBEEF);
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[27] == 1'b0, "R6 valid cleared on accept", cmd_rdata[27], 0);

    // R7: write while busy is ignored
    f0 = nframes;
    cmd_wr = 1'b1; cmd_wdata = mkcmd(1'b1, 5'd17, 5'd22, 16'h1111);
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[26:0] == {1'b0, 5'd9, 5'd3, 16'hBEEF}, "R7 fields kept while busy",
        cmd_rdata[26:0], {1'b0, 5'd9, 5'd3, 16'hBEEF});
    while (cmd_rdata[28]) @(negedge clk);
    wait_cyc(300);
    chk(nframes == f0 + 1 && preg[3][9] == 16'hBEEF, "R7 single frame", nframes - f0, 1);

    // R9/R11: poller with a stable register
    c0 = done_cnt; p0 = npoll;
    poll_phy = 5'd5;
    poll_en = 1'b1;
    wait_cyc(2500);
    chk(npoll >= p0 + 3, "R9 poll reads register 1", npoll - p0, 3);
    chk(chg_cnt == 0, "R9 no change on stable value", chg_cnt, 0);
    chk(done_cnt == c0, "R11 no done for poll frames", done_cnt, c0);

    // R9: change of register 1 gives exactly one pulse
    base = preg[5][1];
    run_cmd(mkcmd(1'b0, 5'd5, 5'd1, base ^ 16'h0400), "wr1");
    wait_cyc(2500);
    chk(chg_cnt == 1, "R9 one change pulse", chg_cnt, 1);

    // R10: CPU reads while polling return their own data
    for (int k = 0; k < 4; k++) begin
      run_cmd(mkcmd(1'b1, 5'(9 + k), 5'(2 + k), 16'h0), "rdp");
      chk(cmd_rdata[15:0] == preg[9 + k][2 + k], "R10 cpu read under polling",
          cmd_rdata[15:0], preg[9 + k][2 + k]);
    end
    w = cmd_rdata;
    wait_cyc(1500);
    chk(cmd_rdata == w, "R10 poll leaves status word", cmd_rdata, w);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule